// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block is a small peripheral that hangs on a shared system bus clocked by a bus clock. The bus clock's high half is the peripheral phase, when the address, the read/write line and the write data are valid. The block decodes three addresses. Two of them are read-only: a status word and a data-in word. The third is a write-only data-out word whose bits drive indicator lines such as LEDs directly.

The data-in word is not the raw external input. It is a capture register that samples the external lines on every rising bus-clock edge. It skips the sample while a read of that word is under way, so the value stays frozen for the whole read. Bit 0 of the status word is set when a capture brings in a value different from the one held. It is cleared by reading the data-in word.

Read data leaves the block as a per-bit value plus a per-bit output enable, one driver for each data line. All the enables share one decoded select that is active only in the peripheral phase of a read of a readable address. The data-out word is clocked by a strobe that is the complement of (bus clock high AND data-out address AND write). Its rising edge therefore lands at the end of the peripheral phase, when the bus clock falls.

Top module: `pio_port`

## Requirements
- R1: While reset is asserted, `led_o` is 0 and `bus_oe_o` is 0, whatever the bus carries. After reset, the data-in word and status bit 0 read as 0 until a changed input is captured.
- R2: A write cycle (`bus_wr_i`=1) to the data-out address (2) loads `bus_wdata_i` into `led_o` at the falling bus-clock edge that ends the peripheral phase. During that high phase `led_o` still shows its old value.
- R3: `led_o` keeps its value through every bus cycle that is not a write to address 2.
- R4: During the high phase of a read (`bus_wr_i`=0) of address 0 or 1, every bit of `bus_oe_o` is 1. In the low phase, and in every other cycle, every bit is 0.
- R5: A read of address 1 returns the external value captured at the last rising edge before the read. A change on `ext_in_i` during the read does not alter the returned data.
- R6: A read of address 0 returns bit 0 as the new-data flag and all other bits as 0. The flag is set after a capture of a value different from the one held, and it is clear after any read of address 1.
- R7: A write to address 0 or 1 is ignored: no drive on the bus, `led_o` unchanged, and the data-in word and status flag unchanged.
- R8: A read of address 2 is ignored: no drive on the bus and `led_o` unchanged.
- R9: Addresses other than 0, 1 and 2 are neither driven nor stored, for reads and for writes.
- R10: A capture of a value equal to the one held leaves the status flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bus clock; high = peripheral phase |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | AW | Register address on the bus |
| bus_wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata_i | input | DW | Write data from the bus |
| bus_rdata_o | output | DW | Read data toward the bus drivers (0 when not driving) |
| bus_oe_o | output | DW | Per-line output enable of the bus drivers |
| ext_in_i | input | DW | External input lines |
| led_o | output | DW | Data-out word driving indicator lines |

## Verification
A data-in register that captures during a read shows up on the very next read of address 1: the returned value is the one from the read cycle, not the earlier capture. A stuck or wrongly cleared new-data flag is visible on the first status read after the faulty edge. A wrong write-strobe edge or decode changes `led_o` either mid-way through the high phase or on a cycle that was not a write to address 2, and the bench checks this every bus cycle. Every cycle also compares the enables in both clock phases, so a misdecoded read select shows at once.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_INPUT  = 2'd2,
    SEL_OUTPUT = 2'd3
  } pio_sel_e;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int ADDR_ST = 0,
  parameter int ADDR_IN = 1,
  parameter int ADDR_OUT = 2
) (
  input  logic          bclk_i,
  input  logic          rst_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  output pio_sel_e      sel_o,
  output logic          in_rd_o,
  output logic          out_wclk_o,
  output logic [DW-1:0] oe_o
);
  localparam logic [AW-1:0] A_ST  = ADDR_ST[AW-1:0];
  localparam logic [AW-1:0] A_IN  = ADDR_IN[AW-1:0];
  localparam logic [AW-1:0] A_OUT = ADDR_OUT[AW-1:0];

  pio_sel_e sel;
  logic     rd_hit;
  logic     rd_en;
  logic     out_load_raw;

  always_comb begin
    if      (addr_i == A_ST)  sel = SEL_STATUS;
    else if (addr_i == A_IN)  sel = SEL_INPUT;
    else if (addr_i == A_OUT) sel = SEL_OUTPUT;
    else                      sel = SEL_NONE;
  end

  assign rd_hit = !wr_i && ((sel == SEL_STATUS) || (sel == SEL_INPUT));
  assign rd_en  = rst_n_i && bclk_i && rd_hit;

  // Raw load condition falls where the load belongs; its complement rises there.
  assign out_load_raw = bclk_i && wr_i && (sel == SEL_OUTPUT);
  assign out_wclk_o   = ~out_load_raw;

  assign in_rd_o = !wr_i && (sel == SEL_INPUT);
  assign sel_o   = sel;

  for (genvar g = 0; g < DW; g++) begin : g_drv_en
    assign oe_o[g] = rd_en;
  end
endmodule

// File: rtl/pio_in_capture.sv
module pio_in_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic [DW-1:0] ext_i,
  input  logic          hold_i,
  output logic [DW-1:0] data_o,
  output logic          fresh_o
);
  logic [DW-1:0] data_q, data_d;
  logic          fresh_q, fresh_d;
  logic          cap_en;

  assign cap_en = !hold_i;

  always_comb begin
    data_d  = data_q;
    fresh_d = fresh_q;
    if (cap_en) begin
      data_d = ext_i;
      if (ext_i != data_q) fresh_d = 1'b1;
    end else begin
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      fresh_q <= fresh_d;
    end
  end

  assign data_o  = data_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/pio_out_reg.sv
module pio_out_reg #(
  parameter int DW = 8
) (
  input  logic          wclk_i,
  input  logic          rst_n_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_r;

  always_ff @(posedge wclk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_r <= '0;
    else          q_r <= wdata_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int ADDR_ST  = 0,
  parameter int ADDR_IN  = 1,
  parameter int ADDR_OUT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bclk_i,
  input  logic          rst_n_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic [DW-1:0] bus_oe_o,
  input  logic [DW-1:0] ext_in_i,
  output logic [DW-1:0] led_o
);
  logic          rst_sync_n;
  pio_sel_e      sel;
  logic          in_rd;
  logic          out_wclk;
  logic [DW-1:0] oe;
  logic [DW-1:0] in_data;
  logic          fresh;
  logic [DW-1:0] status_word;

  pio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i    (bclk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_sync_n)
  );

  pio_decode #(
    .AW(AW), .DW(DW), .ADDR_ST(ADDR_ST), .ADDR_IN(ADDR_IN), .ADDR_OUT(ADDR_OUT)
  ) u_decode (
    .bclk_i     (bclk_i),
    .rst_n_i    (rst_sync_n),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .sel_o      (sel),
    .in_rd_o    (in_rd),
    .out_wclk_o (out_wclk),
    .oe_o       (oe)
  );

  pio_in_capture #(.DW(DW)) u_in_capture (
    .clk_i   (bclk_i),
    .rst_n_i (rst_sync_n),
    .ext_i   (ext_in_i),
    .hold_i  (in_rd),
    .data_o  (in_data),
    .fresh_o (fresh)
  );

  pio_out_reg #(.DW(DW)) u_out_reg (
    .wclk_i  (out_wclk),
    .rst_n_i (rst_sync_n),
    .wdata_i (bus_wdata_i),
    .q_o     (led_o)
  );

  assign status_word = {{(DW-1){1'b0}}, fresh};

  always_comb begin
    bus_rdata_o = '0;
    if (oe[0]) begin
      if (sel == SEL_STATUS) bus_rdata_o = status_word;
      else                   bus_rdata_o = in_data;
    end
  end

  assign bus_oe_o = oe;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int ADDR_IN  = 1,
  parameter int ADDR_OUT = 2
) (
  input logic          bclk_i,
  input logic          rst_sync_n,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_wr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] bus_oe_o,
  input logic [DW-1:0] ext_in_i,
  input logic [DW-1:0] led_o,
  input logic [DW-1:0] in_data,
  input logic          fresh
);
  localparam logic [AW-1:0] A_IN  = ADDR_IN[AW-1:0];
  localparam logic [AW-1:0] A_OUT = ADDR_OUT[AW-1:0];

  logic out_wr, in_rd;
  assign out_wr = bus_wr_i && (bus_addr_i == A_OUT);
  assign in_rd  = !bus_wr_i && (bus_addr_i == A_IN);

  always_comb begin
    if (rst_sync_n === 1'b1) begin
      assert_oe_uniform_R4: assert (bus_oe_o == '0 || bus_oe_o == '1);
    end
  end

  assert_out_load_R2: assert property (@(negedge bclk_i) disable iff (!rst_sync_n)
    out_wr |=> (led_o == $past(bus_wdata_i)));

  assert_out_keep_R3: assert property (@(negedge bclk_i) disable iff (!rst_sync_n)
    !out_wr |=> $stable(led_o));

  assert_in_hold_R5: assert property (@(posedge bclk_i) disable iff (!rst_sync_n)
    in_rd |=> $stable(in_data));

  assert_flag_clear_R6: assert property (@(posedge bclk_i) disable iff (!rst_sync_n)
    in_rd |=> !fresh);

  assert_flag_keep_R10: assert property (@(posedge bclk_i) disable iff (!rst_sync_n)
    (!in_rd && (ext_in_i == in_data)) |=> $stable(fresh));
endmodule

bind pio_port pio_port_chk #(
  .AW(AW), .DW(DW), .ADDR_IN(ADDR_IN), .ADDR_OUT(ADDR_OUT)
) u_chk (
  .bclk_i      (bclk_i),
  .rst_sync_n  (rst_sync_n),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_oe_o    (bus_oe_o),
  .ext_in_i    (ext_in_i),
  .led_o       (led_o),
  .in_data     (in_data),
  .fresh       (fresh)
);

// File: tb/pio_port_tb.sv
`timescale 1ns/1ps
module pio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] ext;
  logic [7:0] rdata, oe, led;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] led_m, in_m;
  logic       flag_m;

  always #10 clk = ~clk;

  pio_port u_dut (
    .bclk_i(clk), .rst_n_i(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_oe_o(oe),
    .ext_in_i(ext), .led_o(led)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string oe_tag(input logic [3:0] a, input logic w);
    if (w && a < 4'd2)  return "R7";
    if (!w && a == 4'd2) return "R8";
    if (a > 4'd2)       return "R9";
    return "R4";
  endfunction

  // Called at negedge+1; covers one full bus cycle and returns at the next negedge+1.
  task automatic bus_cycle(input logic [3:0] a, input logic w, input logic [7:0] wd,
                           input logic [7:0] ex, input string note);
    logic       rd;
    logic [7:0] exp_rd;
    string      tg;
    #1;
    addr = a; wr = w; wdata = wd; ext = ex;
    @(posedge clk);
    if (!w && a == 4'd1) flag_m = 1'b0;
    else begin
      if (ex != in_m) flag_m = 1'b1;
      in_m = ex;
    end
    #5;
    rd = !w && (a == 4'd0 || a == 4'd1);
    if (rd) begin
      exp_rd = (a == 4'd0) ? {7'b0, flag_m} : in_m;
      tg = (note != "") ? note : ((a == 4'd0) ? "R6" : "R5");
      chk(oe, 8'hFF, "R4");
      chk(rdata, exp_rd, tg);
    end else begin
      chk(oe, 8'h00, oe_tag(a, w));
    end
    chk(led, led_m, (w && a == 4'd2) ? "R2" : "R3");
    @(negedge clk);
    if (w && a == 4'd2) led_m = wd;
    #1;
    chk(led, led_m, (w && a == 4'd2) ? "R2" : "R3");
    chk(oe, 8'h00, "R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; addr = 4'd0; wr = 1'b0; wdata = 8'h00; ext = 8'h00;
    led_m = 8'h00; in_m = 8'h00; flag_m = 1'b0;
    // R1: a read of address 0 during reset must not drive the bus.
    repeat (2) @(posedge clk);
    #5;
    chk(oe, 8'h00, "R1");
    chk(led, 8'h00, "R1");
    @(negedge clk); #1;
    addr = 4'd3;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(led, 8'h00, "R1");
    chk(oe, 8'h00, "R1");
    bus_cycle(4'd0, 1'b0, 8'h00, 8'h00, "R1");
    bus_cycle(4'd1, 1'b0, 8'h00, 8'h00, "R1");

    bus_cycle(4'd2, 1'b1, 8'hA5, 8'h00, "");   // R2
    bus_cycle(4'd2, 1'b0, 8'h00, 8'h00, "");   // R8
    bus_cycle(4'd0, 1'b1, 8'hFF, 8'h00, "");   // R7
    bus_cycle(4'd1, 1'b1, 8'h3C, 8'h00, "");   // R7
    bus_cycle(4'd1, 1'b0, 8'h00, 8'h00, "R7");
    bus_cycle(4'd3, 1'b0, 8'h00, 8'h5A, "");
    bus_cycle(4'd0, 1'b0, 8'h00, 8'h5A, "R6");
    bus_cycle(4'd1, 1'b0, 8'h00, 8'hC3, "R5"); // input changes during the read
    bus_cycle(4'd3, 1'b0, 8'h00, 8'h5A, "");
    bus_cycle(4'd0, 1'b0, 8'h00, 8'h5A, "R10");
    bus_cycle(4'd7, 1'b0, 8'h00, 8'h5A, "");   // R9
    bus_cycle(4'd9, 1'b1, 8'h77, 8'h5A, "");   // R9
    bus_cycle(4'd2, 1'b1, 8'h00, 8'h5A, "");   // R2 all-zero load
    bus_cycle(4'd2, 1'b1, 8'hFF, 8'h5A, "");   // R2 all-one load

    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [7:0] ex;
      a  = 4'($urandom % 6);
      ex = ($urandom % 3 == 0) ? 8'($urandom) : ext;
      bus_cycle(a, 1'($urandom % 2), 8'($urandom), ex, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule